// File: doc/BRIEF.md
# Floppy Controller Host Register Bank

This block is the processor-facing side of a four-drive floppy disk controller. It decodes an eight-byte I/O window. A 3-bit offset selects the register, and separate read and write strobes qualify the access. Through this window the host can read a status byte, a result type and a result byte. It builds a 16-bit pointer to a parameter block in memory from two byte writes. The second write also launches the operation. A soft reset is issued by writing one offset.

A separate command engine receives the pointer and a one-cycle start pulse. When the engine finishes, it returns a completion strobe together with a result type, an error byte and a request to raise the interrupt. Each drive supplies a ready line and an attached line. The block tracks the drives that are both attached and ready, and records any change in that set. The host can then fetch the new set through the result byte, where the drive bits appear in a scrambled order. The interrupt flip-flop drives the interrupt request pin directly. A read of the result type clears it.

The read data is combinational from the selected offset and the register state. Side effects of a read (clearing the interrupt, consuming the ready-change flag) take place on the clock edge at which the read strobe is sampled.

Top module: `fdc_host_regs`

## Requirements
- R1: Reading offset 0 returns the status byte with this layout:
  - bit 0: drive 0 ready
  - bit 1: drive 1 ready
  - bit 2: interrupt flip-flop
  - bit 3: board present, always 1
  - bit 4: double density, always 1
  - bit 5: drive 2 ready
  - bit 6: drive 3 ready
  - bit 7: always 0

  A drive counts as ready when its attached and ready inputs are both high, as sampled at the previous clock edge.
- R2: Reading offset 1 returns the 2-bit result type in bits 1:0, with bits 7:2 zero. The clock edge that samples that read clears the interrupt flip-flop.
- R3: A write to offset 1 sets the pointer to {0x00, data}. A write to offset 2 ORs the data into pointer bits 15:8 and starts an operation. The start output is high for exactly the one cycle after that edge, and the updated pointer is on the pointer output in the same cycle.
- R4: From an accepted start until the engine's done strobe, the block is busy. While busy, writes to offsets 1 and 2 are ignored: the pointer is unchanged and no start is issued.
- R5: When the result type is 00, reading offset 3 returns the last error byte captured from the engine.
- R6: When the result type is 10 and the ready-change flag is set, offset 3 returns a ready byte:
  - bit 4: drive 2
  - bit 5: drive 3
  - bit 6: drive 0
  - bit 7: drive 1
  - bits 3:0: zero

  In every other case, including result types 01 and 11, offset 3 returns 0.
- R7: The ready-change flag is set on any clock edge at which the sampled ready set differs from the stored one. A read of offset 3 that returns the ready byte clears the flag, unless a change occurs on that same edge.
- R8: On the engine's done strobe, the block captures the result type and the error byte. If the interrupt request is also high, the interrupt flip-flop is set, and this set takes priority over a clear from a simultaneous offset-1 read.
- R9: A write to offset 7 is a soft reset. It clears the interrupt flip-flop and the ready-change flag, sets the result type to 10, and reloads the ready bits from the attached drives. A done strobe on the same edge is discarded.
- R10: After the hardware reset, status reads 0x18, the result type is 10, offset 3 reads 0, the interrupt request is low, the pointer is 0 and no start is pending.
- R11: Reads of offsets 2, 4, 5, 6 and 7 return 0x00. Writes to offsets 0, 3, 4, 5 and 6 change no state.
- R12: The interrupt request output always equals the interrupt flip-flop, and therefore equals status bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register offset within the window |
| bus_rd | input | 1 | Read strobe, side effects on the sampling edge |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed offset |
| drv_ready | input | 4 | Per-drive ready lines |
| drv_attached | input | 4 | Per-drive attached lines |
| eng_start | output | 1 | One-cycle launch pulse to the command engine |
| eng_ptr | output | 16 | Parameter-block pointer |
| eng_done | input | 1 | Engine completion strobe |
| eng_rtype | input | 2 | Result type from the engine |
| eng_err | input | 8 | Error byte from the engine |
| eng_irq_set | input | 1 | Engine requests the interrupt flip-flop be set |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle:
- the fixed status bits, the zero upper bits of the result type and the zero reads of unused offsets;
- that the interrupt pin matches status bit 2;
- that a start is single-cycle and caused by a write to offset 2;
- that an offset-1 read clears the interrupt, a soft reset leaves type 10, and a completion with an interrupt request raises the pin.

Only the bench's scenarios can show:
- the scrambled ready-byte order;
- the consumption of the ready-change flag;
- the suppression of pointer writes while busy;
- the priority between a completion and a simultaneous read or soft reset.

The bench shows these by running a behavioural model alongside the block and comparing every output each cycle.

// File: rtl/fdc_host_pkg.sv
package fdc_host_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;
  localparam int PTR_W  = 16;
  localparam int NDRV   = 4;
  localparam int RT_W   = 2;

  localparam logic [ADDR_W-1:0] OFS_STATUS = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_RTYPE  = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_PTR_HI = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_RBYTE  = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_SRESET = 3'd7;

  localparam logic [RT_W-1:0] RT_ERROR = 2'b00;
  localparam logic [RT_W-1:0] RT_READY = 2'b10;
endpackage

// File: rtl/fdc_ready_track.sv
module fdc_ready_track
  import fdc_host_pkg::*;
#(
  parameter int N = NDRV
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] drv_ready,
  input  logic [N-1:0] drv_attached,
  input  logic         soft_rst,
  input  logic         chg_consume,
  output logic [N-1:0] rdy_q,
  output logic         chg_q
);
  logic [N-1:0] live;
  logic [N-1:0] rdy_d;
  logic         chg_d;

  always_comb begin
    live  = drv_ready & drv_attached;
    rdy_d = live;
    chg_d = chg_q;
    if (soft_rst) begin
      chg_d = 1'b0;
    end else if (live != rdy_q) begin
      chg_d = 1'b1;
    end else if (chg_consume) begin
      chg_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= '0;
      chg_q <= 1'b0;
    end else begin
      rdy_q <= rdy_d;
      chg_q <= chg_d;
    end
  end
endmodule

// File: rtl/fdc_launch.sv
module fdc_launch
  import fdc_host_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int PW = PTR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [DW-1:0] wdata,
  input  logic          done,
  output logic [PW-1:0] ptr_q,
  output logic          start_q,
  output logic          busy_q
);
  localparam int HI_W = PW - DW;

  logic          acc_lo;
  logic          acc_hi;
  logic [PW-1:0] ptr_d;
  logic          start_d;
  logic          busy_d;
  logic          ptr_en;

  always_comb begin
    acc_lo  = wr_lo & ~busy_q;
    acc_hi  = wr_hi & ~busy_q;
    ptr_en  = acc_lo | acc_hi;
    ptr_d   = ptr_q;
    if (acc_lo) begin
      ptr_d = {{HI_W{1'b0}}, wdata};
    end else if (acc_hi) begin
      ptr_d = ptr_q | {wdata[HI_W-1:0], {DW{1'b0}}};
    end
    start_d = acc_hi;
    busy_d  = busy_q;
    if (acc_hi) begin
      busy_d = 1'b1;
    end else if (done) begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      start_q <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      if (ptr_en) begin
        ptr_q <= ptr_d;
      end
      start_q <= start_d;
      busy_q  <= busy_d;
    end
  end
endmodule

// File: rtl/fdc_result.sv
module fdc_result
  import fdc_host_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            soft_rst,
  input  logic            rd_type,
  input  logic            done,
  input  logic [RT_W-1:0] eng_rtype,
  input  logic [DW-1:0]   eng_err,
  input  logic            eng_irq_set,
  output logic [RT_W-1:0] rtype_q,
  output logic [DW-1:0]   err_q,
  output logic            int_q
);
  logic [RT_W-1:0] rtype_d;
  logic [DW-1:0]   err_d;
  logic            int_d;
  logic            err_en;

  always_comb begin
    rtype_d = rtype_q;
    err_d   = err_q;
    err_en  = 1'b0;
    int_d   = int_q & ~rd_type;
    if (soft_rst) begin
      rtype_d = RT_READY;
      int_d   = 1'b0;
    end else if (done) begin
      rtype_d = eng_rtype;
      err_d   = eng_err;
      err_en  = 1'b1;
      int_d   = int_d | eng_irq_set;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rtype_q <= RT_READY;
      err_q   <= '0;
      int_q   <= 1'b0;
    end else begin
      rtype_q <= rtype_d;
      if (err_en) begin
        err_q <= err_d;
      end
      int_q <= int_d;
    end
  end
endmodule

// File: rtl/fdc_rd_mux.sv
module fdc_rd_mux
  import fdc_host_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int N  = NDRV
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [N-1:0]      rdy,
  input  logic              int_ff,
  input  logic              chg,
  input  logic [RT_W-1:0]   rtype,
  input  logic [DW-1:0]     err,
  output logic [DW-1:0]     rdata
);
  logic [DW-1:0] status_b;
  logic [DW-1:0] ready_b;
  logic [DW-1:0] rbyte_b;

  always_comb begin
    status_b = {1'b0, rdy[3], rdy[2], 1'b1, 1'b1, int_ff, rdy[1], rdy[0]};
    ready_b  = {rdy[1], rdy[0], rdy[3], rdy[2], 4'b0000};
    if (rtype == RT_ERROR) begin
      rbyte_b = err;
    end else if (rtype == RT_READY && chg) begin
      rbyte_b = ready_b;
    end else begin
      rbyte_b = '0;
    end
    unique case (addr)
      OFS_STATUS: rdata = status_b;
      OFS_RTYPE:  rdata = {{(DW-RT_W){1'b0}}, rtype};
      OFS_RBYTE:  rdata = rbyte_b;
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/fdc_host_regs.sv
module fdc_host_regs
  import fdc_host_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_rd,
  input  logic               bus_wr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NDRV-1:0]    drv_ready,
  input  logic [NDRV-1:0]    drv_attached,
  output logic               eng_start,
  output logic [PTR_W-1:0]   eng_ptr,
  input  logic               eng_done,
  input  logic [RT_W-1:0]    eng_rtype,
  input  logic [DATA_W-1:0]  eng_err,
  input  logic               eng_irq_set,
  output logic               irq
);
  logic            wr_lo, wr_hi, soft_rst, rd_type, chg_consume;
  logic [NDRV-1:0] rdy_q;
  logic            chg_q;
  logic [RT_W-1:0] rtype_q;
  logic [DATA_W-1:0] err_q;
  logic            int_q;
  logic            busy_q;

  always_comb begin
    wr_lo       = bus_wr && (bus_addr == OFS_RTYPE);
    wr_hi       = bus_wr && (bus_addr == OFS_PTR_HI);
    soft_rst    = bus_wr && (bus_addr == OFS_SRESET);
    rd_type     = bus_rd && (bus_addr == OFS_RTYPE);
    chg_consume = bus_rd && (bus_addr == OFS_RBYTE) && (rtype_q == RT_READY) && chg_q;
  end

  fdc_ready_track #(.N(NDRV)) u_ready (
    .clk(clk), .rst_n(rst_n), .drv_ready(drv_ready), .drv_attached(drv_attached),
    .soft_rst(soft_rst), .chg_consume(chg_consume), .rdy_q(rdy_q), .chg_q(chg_q)
  );

  fdc_launch #(.DW(DATA_W), .PW(PTR_W)) u_launch (
    .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi), .wdata(bus_wdata),
    .done(eng_done), .ptr_q(eng_ptr), .start_q(eng_start), .busy_q(busy_q)
  );

  fdc_result #(.DW(DATA_W)) u_result (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .rd_type(rd_type), .done(eng_done),
    .eng_rtype(eng_rtype), .eng_err(eng_err), .eng_irq_set(eng_irq_set),
    .rtype_q(rtype_q), .err_q(err_q), .int_q(int_q)
  );

  fdc_rd_mux #(.DW(DATA_W), .N(NDRV)) u_mux (
    .addr(bus_addr), .rdy(rdy_q), .int_ff(int_q), .chg(chg_q), .rtype(rtype_q),
    .err(err_q), .rdata(bus_rdata)
  );

  assign irq = int_q;
endmodule

// File: rtl/fdc_host_regs_chk.sv
module fdc_host_regs_chk
  import fdc_host_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              eng_start,
  input logic              eng_done,
  input logic              eng_irq_set,
  input logic              irq,
  input logic [RT_W-1:0]   rtype_q
);
  assert_status_fixed_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 3'd0) |-> (bus_rdata[7] == 1'b0 && bus_rdata[4:3] == 2'b11));

  assert_type_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 3'd1) |-> (bus_rdata[7:2] == 6'd0));

  assert_read_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 3'd1 && !eng_done) |=> !irq);

  assert_start_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> $past(bus_wr && bus_addr == 3'd2));

  assert_start_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  assert_done_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && eng_irq_set && !(bus_wr && bus_addr == 3'd7)) |=> irq);

  assert_soft_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd7) |=> (!irq && rtype_q == 2'b10));

  assert_unused_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 3'd2 || bus_addr >= 3'd4) |-> (bus_rdata == 8'h00));

  assert_irq_status_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 3'd0) |-> (bus_rdata[2] == irq));
endmodule

bind fdc_host_regs fdc_host_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_rdata(bus_rdata), .eng_start(eng_start), .eng_done(eng_done),
  .eng_irq_set(eng_irq_set), .irq(irq), .rtype_q(rtype_q)
);

// File: tb/fdc_host_regs_tb.sv
module fdc_host_regs_tb;
  logic        clk;
  logic        rst_n;
  logic [2:0]  bus_addr;
  logic        bus_rd, bus_wr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic [3:0]  drv_ready, drv_attached;
  logic        eng_start;
  logic [15:0] eng_ptr;
  logic        eng_done;
  logic [1:0]  eng_rtype;
  logic [7:0]  eng_err;
  logic        eng_irq_set;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  string scen = "R10";

  // behavioural reference state
  int m_rdy, m_chg, m_rtype, m_err, m_int, m_ptr, m_busy, m_start;

  fdc_host_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .drv_ready(drv_ready),
    .drv_attached(drv_attached), .eng_start(eng_start), .eng_ptr(eng_ptr),
    .eng_done(eng_done), .eng_rtype(eng_rtype), .eng_err(eng_err),
    .eng_irq_set(eng_irq_set), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int bitof(int v, int i);
    return (v >> i) & 1;
  endfunction

  function automatic int exp_rdata(int a);
    if (a == 0)
      return (bitof(m_rdy,3) << 6) | (bitof(m_rdy,2) << 5) | 8'h18 | (m_int << 2)
             | (bitof(m_rdy,1) << 1) | bitof(m_rdy,0);
    if (a == 1) return m_rtype;
    if (a == 3) begin
      if (m_rtype == 0) return m_err;
      if (m_rtype == 2 && m_chg != 0)
        return (bitof(m_rdy,1) << 7) | (bitof(m_rdy,0) << 6) | (bitof(m_rdy,3) << 5)
               | (bitof(m_rdy,2) << 4);
      return 0;
    end
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rdy = 0; m_chg = 0; m_rtype = 2; m_err = 0; m_int = 0;
      m_ptr = 0; m_busy = 0; m_start = 0;
    end else begin
      int live, a, srst, go;
      live = int'(drv_ready & drv_attached);
      a    = int'(bus_addr);
      srst = (bus_wr && a == 7) ? 1 : 0;
      go   = (bus_wr && a == 2 && m_busy == 0) ? 1 : 0;
      // ready set and change flag
      if (srst != 0) m_chg = 0;
      else if (live != m_rdy) m_chg = 1;
      else if (bus_rd && a == 3 && m_rtype == 2 && m_chg != 0) m_chg = 0;
      m_rdy = live;
      // interrupt, result type, error byte
      if (bus_rd && a == 1) m_int = 0;
      if (srst != 0) begin
        m_rtype = 2; m_int = 0;
      end else if (eng_done) begin
        m_rtype = int'(eng_rtype);
        m_err   = int'(eng_err);
        if (eng_irq_set) m_int = 1;
      end
      // pointer and launch
      if (bus_wr && a == 1 && m_busy == 0) m_ptr = int'(bus_wdata);
      if (go != 0) m_ptr = m_ptr | (int'(bus_wdata) << 8);
      m_start = go;
      if (go != 0) m_busy = 1;
      else if (eng_done) m_busy = 0;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s (scenario %s) t=%0t actual=%0h expected=%0h", tag, scen, $time, act, exp);
    end
  endtask

  // comparisons mid-cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      string tag;
      case (int'(bus_addr))
        0: tag = "R1";
        1: tag = "R2";
        3: tag = (m_rtype == 0) ? "R5" : "R6";
        default: tag = "R11";
      endcase
      chk(tag, int'(bus_rdata), exp_rdata(int'(bus_addr)));
      chk("R3", int'(eng_start), m_start);
      chk("R3", int'(eng_ptr), m_ptr);
      chk("R12", int'(irq), m_int);
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    bus_rd = 0; bus_wr = 0; eng_done = 0; eng_irq_set = 0;
  endtask

  task automatic rd(int a);
    bus_addr = 3'(a); bus_rd = 1; step(); idle();
  endtask

  task automatic wr(int a, int d);
    bus_addr = 3'(a); bus_wdata = 8'(d); bus_wr = 1; step(); idle();
  endtask

  task automatic fin(int rt, int er, int ir);
    eng_done = 1; eng_rtype = 2'(rt); eng_err = 8'(er); eng_irq_set = ir[0]; step(); idle();
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 0; bus_addr = 0; bus_wdata = 0; drv_ready = 0; drv_attached = 0;
    eng_rtype = 0; eng_err = 0; idle();
    repeat (3) step();
    rst_n = 1; step();

    scen = "R10";
    bus_addr = 0; #3; chk("R10", int'(bus_rdata), 8'h18);
    bus_addr = 1; #1; chk("R10", int'(bus_rdata), 8'h02);
    bus_addr = 3; #1; chk("R10", int'(bus_rdata), 8'h00);
    chk("R10", int'(irq), 0); chk("R10", int'(eng_ptr), 0);
    step();

    scen = "R7";
    drv_attached = 4'b1111; drv_ready = 4'b0101; step();
    bus_addr = 0; step();
    bus_addr = 3; #3; chk("R6", int'(bus_rdata), 8'h50);
    rd(3); bus_addr = 3; #3; chk("R7", int'(bus_rdata), 8'h00);
    drv_ready = 4'b1010; step(); rd(3);
    drv_attached = 4'b0111; drv_ready = 4'b1111; bus_addr = 3; bus_rd = 1; step(); idle();
    bus_addr = 0; step(); rd(3);

    scen = "R9";
    drv_ready = 4'b0011; step();
    wr(7, 0); bus_addr = 3; #3; chk("R9", int'(bus_rdata), 8'h00);
    rd(0);

    scen = "R4";
    wr(1, 8'h34); wr(2, 8'h12); step();
    wr(1, 8'h99); wr(2, 8'h77); step();
    fin(0, 8'h28, 1);
    bus_addr = 3; #3; chk("R5", int'(bus_rdata), 8'h28);
    chk("R8", int'(irq), 1);
    rd(0); rd(1); rd(0);

    scen = "R8";
    wr(1, 8'h01); wr(2, 8'h80); step(); step();
    bus_addr = 1; bus_rd = 1; fin(0, 8'h81, 1);
    chk("R8", int'(irq), 1);
    rd(3); rd(1);
    wr(2, 8'h01); fin(1, 8'h44, 0); rd(3); rd(1);
    wr(2, 8'h02); fin(3, 8'h44, 1); rd(3); rd(0);
    fin(2, 8'h00, 1); drv_ready = 4'b1100; step(); rd(3); rd(3);

    scen = "R9";
    wr(2, 8'h05); step();
    bus_addr = 7; bus_wr = 1; eng_done = 1; eng_rtype = 0; eng_err = 8'hFF; eng_irq_set = 1;
    step(); idle();
    chk("R9", int'(irq), 0);
    rd(1); rd(3);
    fin(0, 8'h11, 1); wr(7, 0); rd(0); rd(1);

    scen = "R11";
    for (int a = 0; a < 8; a++) rd(a);
    wr(0, 8'hFF); wr(3, 8'hFF); wr(4, 8'hAA); wr(5, 8'h55); wr(6, 8'h0F);
    for (int a = 0; a < 8; a++) rd(a);

    scen = "R3";
    wr(1, 8'hCD); wr(2, 8'hAB); step(); fin(2, 0, 0);
    wr(1, 8'h0F); wr(2, 8'hF0); step(); fin(2, 0, 1); rd(1);
    repeat (3) step();
    summary();
  end
endmodule